// File: doc/BRIEF.md
# Reservation Station Bank with Broadcast Wakeup

This block holds instructions that have been issued to one pipelined functional unit but cannot yet run. Each issue delivers an operation code and two source operands. Each operand arrives either as a value or as the 4-bit tag of the station that will produce it. A tag of zero means the operand is already a value, and no separate ready flag is kept. The issue port places the instruction into a free station and reports that station's tag. The tag space 1 to 15 is shared by every station bank in the machine, and tag 0 means "no producer".

Every station watches a shared result broadcast bus. The bus carries a valid strobe, a 64-bit value and the tag of the station that produced it. A waiting station whose stored tag matches the bus tag takes the value and clears the tag. Once both operands are present the station can be dispatched. When several stations are ready, the one issued earliest is chosen. A dispatched station stays occupied until its own tag appears on the bus, which means the unit's result has been broadcast, and it is then free again.

Top module: `rsb_bank`

## Requirements
- R1: After synchronous reset every station is free, `issue_ready` is 1 and `disp_valid` is 0.
- R2: An accepted issue goes to the free station with the lowest index, and `issue_tag` reports BASE_TAG plus that index (tags 1, 2, 3 by default).
- R3: When no station is free, `issue_ready` is 0 and an issue request has no effect on any station.
- R4: An operand issued with tag 0 is taken as a value. An operand issued with a nonzero tag is pending until that tag is broadcast.
- R5: When `bc_valid` is 1 and `bc_tag` equals a waiting station's pending tag, that station stores `bc_data` as the operand and clears the tag at the same clock edge.
- R6: If an operand's producer tag is on the bus in the same cycle as the issue, the station captures `bc_data` at issue and does not wait.
- R7: `disp_valid` is 1 only while some station holds both operands and has not been dispatched. Dispatch presents that station's operation, both operand values and its tag, and dispatches at most one station per cycle.
- R8: Among ready stations, the one issued earliest is dispatched first, whatever its index.
- R9: A dispatched station is released at the edge where its own tag is broadcast, and it can be allocated again from the next cycle.
- R10: A station is dispatched only once per issue and never while it waits for its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | 3 | Operation code for the unit |
| issue_tag_a | input | 4 | Producer tag of operand A, 0 if value given |
| issue_val_a | input | 64 | Value of operand A |
| issue_tag_b | input | 4 | Producer tag of operand B, 0 if value given |
| issue_val_b | input | 64 | Value of operand B |
| issue_ready | output | 1 | A station is free; issue is accepted this cycle |
| issue_tag | output | 4 | Tag of the station that would take the issue |
| bc_valid | input | 1 | Result broadcast strobe |
| bc_tag | input | 4 | Tag of the producing station |
| bc_data | input | 64 | Broadcast result value |
| disp_valid | output | 1 | A station is dispatched to the unit this cycle |
| disp_op | output | 3 | Operation code of the dispatched station |
| disp_src_a | output | 64 | Operand A of the dispatched station |
| disp_src_b | output | 64 | Operand B of the dispatched station |
| disp_tag | output | 4 | Tag of the dispatched station |

## Verification
An issue and a result broadcast can fall in the same cycle. The bus may then carry the producer of the operand being issued, and at the same edge it may wake other waiting stations or release a dispatched one. The bench provokes this directly by issuing an operand tag while that very tag is on the bus. Random runs also issue operands tagged with this bank's own busy stations, whose results arrive from a modelled unit pipeline at unpredictable times. Each cycle the bench predicts from its own station model whether a dispatch occurs, which station it picks by issue age, and which operand values it carries, and compares all of these at the ports.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    localparam int DATA_W = 64;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef enum logic [1:0] {ST_FREE, ST_WAIT, ST_EXEC} st_e;

    // operand slot: q == 0 means v is valid
    typedef struct packed {
        tag_t  q;
        word_t v;
    } opnd_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t data;
    } bcast_t;

    // capture a broadcast value into a pending operand slot
    function automatic opnd_t snoop(opnd_t cur, bcast_t b);
        opnd_t r;
        r = cur;
        if (b.valid && cur.q != '0 && b.tag == cur.q) begin
            r.q = '0;
            r.v = b.data;
        end
        return r;
    endfunction
endpackage

// File: rtl/rsb_entry.sv
module rsb_entry import rsb_pkg::*; #(
    parameter int MY_TAG = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc,
    input  op_t    in_op,
    input  opnd_t  in_a,
    input  opnd_t  in_b,
    input  bcast_t bus,
    input  logic   grant,
    output st_e    state,
    output op_t    op,
    output opnd_t  src_a,
    output opnd_t  src_b,
    output logic   ready
);
    localparam tag_t OWN = tag_t'(MY_TAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FREE;
            op    <= '0;
            src_a <= '0;
            src_b <= '0;
        end else begin
            case (state)
                ST_FREE: if (alloc) begin
                    state <= ST_WAIT;
                    op    <= in_op;
                    src_a <= snoop(in_a, bus);
                    src_b <= snoop(in_b, bus);
                end
                ST_WAIT: begin
                    src_a <= snoop(src_a, bus);
                    src_b <= snoop(src_b, bus);
                    if (grant) state <= ST_EXEC;
                end
                ST_EXEC: if (bus.valid && bus.tag == OWN) state <= ST_FREE;
                default: state <= ST_FREE;
            endcase
        end
    end

    assign ready = (state == ST_WAIT) && (src_a.q == '0) && (src_b.q == '0);
endmodule

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
    parameter int N = 3
) (
    input  logic [N-1:0] free_v,
    output logic [N-1:0] pick,
    output logic         any_free
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_v[i]) pick = N'(1) << i;
        end
    end
    assign any_free = |free_v;
endmodule

// File: rtl/rsb_age_select.sv
module rsb_age_select #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] ready,
    output logic [N-1:0] grant
);
    // older[j][i] = 1 : station j was issued before station i
    logic [N-1:0] older [N];
    logic [N-1:0] blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) older[i] <= '0;
        end else begin
            for (int n = 0; n < N; n++) begin
                if (alloc[n]) begin
                    for (int j = 0; j < N; j++) begin
                        if (j != n) begin
                            older[j][n] <= 1'b1;
                            older[n][j] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older[j][i]) blocked[i] = 1'b1;
            end
            grant[i] = ready[i] && !blocked[i];
        end
    end
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank import rsb_pkg::*; #(
    parameter int NUM_ST   = 3,
    parameter int BASE_TAG = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         issue_valid,
    input  logic [rsb_pkg::OP_W-1:0]     issue_op,
    input  logic [rsb_pkg::TAG_W-1:0]    issue_tag_a,
    input  logic [rsb_pkg::DATA_W-1:0]   issue_val_a,
    input  logic [rsb_pkg::TAG_W-1:0]    issue_tag_b,
    input  logic [rsb_pkg::DATA_W-1:0]   issue_val_b,
    output logic                         issue_ready,
    output logic [rsb_pkg::TAG_W-1:0]    issue_tag,
    input  logic                         bc_valid,
    input  logic [rsb_pkg::TAG_W-1:0]    bc_tag,
    input  logic [rsb_pkg::DATA_W-1:0]   bc_data,
    output logic                         disp_valid,
    output logic [rsb_pkg::OP_W-1:0]     disp_op,
    output logic [rsb_pkg::DATA_W-1:0]   disp_src_a,
    output logic [rsb_pkg::DATA_W-1:0]   disp_src_b,
    output logic [rsb_pkg::TAG_W-1:0]    disp_tag
);
    bcast_t bus;
    opnd_t  in_a, in_b;
    logic [NUM_ST-1:0] free_v, pick, alloc_v, ready_v, grant_v, busy_v, exec_v;
    st_e    st     [NUM_ST];
    op_t    st_op  [NUM_ST];
    opnd_t  st_a   [NUM_ST];
    opnd_t  st_b   [NUM_ST];

    assign bus  = '{valid: bc_valid, tag: bc_tag, data: bc_data};
    assign in_a = '{q: issue_tag_a, v: issue_val_a};
    assign in_b = '{q: issue_tag_b, v: issue_val_b};

    rsb_alloc #(.N(NUM_ST)) u_alloc (
        .free_v   (free_v),
        .pick     (pick),
        .any_free (issue_ready)
    );

    assign alloc_v = issue_valid ? pick : '0;

    generate
        for (genvar g = 0; g < NUM_ST; g++) begin : g_st
            rsb_entry #(.MY_TAG(BASE_TAG + g)) u_entry (
                .clk   (clk),
                .rst   (rst),
                .alloc (alloc_v[g]),
                .in_op (issue_op),
                .in_a  (in_a),
                .in_b  (in_b),
                .bus   (bus),
                .grant (grant_v[g]),
                .state (st[g]),
                .op    (st_op[g]),
                .src_a (st_a[g]),
                .src_b (st_b[g]),
                .ready (ready_v[g])
            );
            assign free_v[g] = (st[g] == ST_FREE);
            assign busy_v[g] = (st[g] != ST_FREE);
            assign exec_v[g] = (st[g] == ST_EXEC);
        end
    endgenerate

    rsb_age_select #(.N(NUM_ST)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .alloc (alloc_v),
        .ready (ready_v),
        .grant (grant_v)
    );

    always_comb begin
        issue_tag  = '0;
        disp_op    = '0;
        disp_src_a = '0;
        disp_src_b = '0;
        disp_tag   = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (pick[i]) issue_tag = tag_t'(BASE_TAG + i);
            if (grant_v[i]) begin
                disp_op    = st_op[i];
                disp_src_a = st_a[i].v;
                disp_src_b = st_b[i].v;
                disp_tag   = tag_t'(BASE_TAG + i);
            end
        end
    end

    assign disp_valid = |grant_v;
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk import rsb_pkg::*; #(
    parameter int N    = 3,
    parameter int BASE = 1
) (
    input logic         clk,
    input logic         rst,
    input logic         issue_valid,
    input logic         issue_ready,
    input logic         bc_valid,
    input logic [TAG_W-1:0] bc_tag,
    input logic [N-1:0] busy_v,
    input logic [N-1:0] exec_v,
    input logic [N-1:0] grant_v,
    input logic [N-1:0] alloc_v
);
    // R7: at most one station handed to the unit per cycle
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_v));

    // R3: a refused issue never adds an occupied station
    assert_stall_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_ready) |=> ($countones(busy_v) <= $past($countones(busy_v))));

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            localparam tag_t MY = tag_t'(BASE + i);

            // R2: allocated station is occupied and waiting next cycle
            assert_alloc_R2: assert property (@(posedge clk) disable iff (rst)
                alloc_v[i] |=> (busy_v[i] && !exec_v[i]));

            // R9: own tag on the bus releases an executing station
            assert_release_R9: assert property (@(posedge clk) disable iff (rst)
                (exec_v[i] && bc_valid && bc_tag == MY) |=> !busy_v[i]);

            // R10: executing state only entered through a grant
            assert_exec_from_grant_R10: assert property (@(posedge clk) disable iff (rst)
                $rose(exec_v[i]) |-> $past(grant_v[i]));

            // R10: no second grant while awaiting the result
            assert_no_regrant_R10: assert property (@(posedge clk) disable iff (rst)
                exec_v[i] |-> !grant_v[i]);
        end
    endgenerate
endmodule

bind rsb_bank rsb_bank_chk #(.N(NUM_ST), .BASE(BASE_TAG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .bc_valid    (bc_valid),
    .bc_tag      (bc_tag),
    .busy_v      (busy_v),
    .exec_v      (exec_v),
    .grant_v     (grant_v),
    .alloc_v     (alloc_v)
);

// File: tb/rsb_bank_tb.sv
module rsb_bank_tb;
    import rsb_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 3;
    localparam int BASE = 1;
    localparam int LAT  = 2;

    logic  clk = 1'b0, rst = 1'b1;
    logic  issue_valid = 1'b0, issue_ready;
    op_t   issue_op = '0;
    tag_t  issue_tag_a = '0, issue_tag_b = '0, issue_tag;
    word_t issue_val_a = '0, issue_val_b = '0;
    logic  bc_valid = 1'b0;
    tag_t  bc_tag = '0;
    word_t bc_data = '0;
    logic  disp_valid;
    op_t   disp_op;
    word_t disp_src_a, disp_src_b;
    tag_t  disp_tag;

    rsb_bank #(.NUM_ST(N), .BASE_TAG(BASE)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;

    // bench model of the stations
    bit    m_busy [N];
    bit    m_exec [N];
    op_t   m_op   [N];
    tag_t  m_qa   [N];
    tag_t  m_qb   [N];
    word_t m_va   [N];
    word_t m_vb   [N];
    int    m_seq  [N];
    int    seq_ctr = 0;
    bit    p_v    [LAT];
    tag_t  p_tag  [LAT];
    word_t p_data [LAT];

    // stimulus for the next cycle
    bit    s_iv = 0, s_xv = 0;
    op_t   s_op = '0;
    tag_t  s_qa = '0, s_qb = '0, s_xt = '0;
    word_t s_va = '0, s_vb = '0, s_xd = '0;

    function automatic word_t unit_fn(op_t op, word_t a, word_t b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            default: return a * b;
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_stim();
        s_iv = 0; s_xv = 0; s_op = '0; s_qa = '0; s_qb = '0;
        s_va = '0; s_vb = '0; s_xt = '0; s_xd = '0;
    endtask

    // one cycle: drive at negedge, check, clock, update model
    task automatic tick();
        bit own;
        int fidx, g;
        own = p_v[LAT-1];
        bc_valid    = own || s_xv;
        bc_tag      = own ? p_tag[LAT-1]  : s_xt;
        bc_data     = own ? p_data[LAT-1] : s_xd;
        issue_valid = s_iv;
        issue_op    = s_op;
        issue_tag_a = s_qa; issue_val_a = s_va;
        issue_tag_b = s_qb; issue_val_b = s_vb;
        #1;
        fidx = -1;
        for (int i = 0; i < N; i++) if (!m_busy[i] && fidx < 0) fidx = i;
        chk(issue_ready == (fidx >= 0), "R3 issue_ready", 64'(issue_ready), 64'(fidx >= 0));
        if (fidx >= 0) chk(issue_tag == tag_t'(BASE + fidx), "R2 issue_tag", 64'(issue_tag), 64'(BASE + fidx));
        g = -1;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !m_exec[i] && m_qa[i] == '0 && m_qb[i] == '0 &&
                (g < 0 || m_seq[i] < m_seq[g])) g = i;
        chk(disp_valid == (g >= 0), "R7 disp_valid", 64'(disp_valid), 64'(g >= 0));
        if (g >= 0 && disp_valid) begin
            chk(disp_tag == tag_t'(BASE + g), "R8 disp_tag", 64'(disp_tag), 64'(BASE + g));
            chk(disp_op == m_op[g], "R7 disp_op", 64'(disp_op), 64'(m_op[g]));
            chk(disp_src_a == m_va[g], "R5 disp_src_a", disp_src_a, m_va[g]);
            chk(disp_src_b == m_vb[g], "R5 disp_src_b", disp_src_b, m_vb[g]);
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (m_busy[i] && !m_exec[i] && bc_valid) begin
                if (m_qa[i] != '0 && m_qa[i] == bc_tag) begin m_qa[i] = '0; m_va[i] = bc_data; end
                if (m_qb[i] != '0 && m_qb[i] == bc_tag) begin m_qb[i] = '0; m_vb[i] = bc_data; end
            end else if (m_exec[i] && bc_valid && bc_tag == tag_t'(BASE + i)) begin
                m_busy[i] = 0; m_exec[i] = 0;
            end
        end
        for (int k = LAT - 1; k > 0; k--) begin
            p_v[k] = p_v[k-1]; p_tag[k] = p_tag[k-1]; p_data[k] = p_data[k-1];
        end
        p_v[0] = (g >= 0);
        if (g >= 0) begin
            m_exec[g] = 1;
            p_tag[0]  = tag_t'(BASE + g);
            p_data[0] = unit_fn(m_op[g], m_va[g], m_vb[g]);
        end
        if (s_iv && fidx >= 0) begin
            m_busy[fidx] = 1; m_exec[fidx] = 0; m_op[fidx] = s_op;
            m_qa[fidx] = s_qa; m_va[fidx] = s_va;
            m_qb[fidx] = s_qb; m_vb[fidx] = s_vb;
            if (bc_valid && s_qa != '0 && s_qa == bc_tag) begin m_qa[fidx] = '0; m_va[fidx] = bc_data; end
            if (bc_valid && s_qb != '0 && s_qb == bc_tag) begin m_qb[fidx] = '0; m_vb[fidx] = bc_data; end
            m_seq[fidx] = seq_ctr++;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        clr_stim();
        for (int i = 0; i < n; i++) tick();
    endtask

    bit done = 0;
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'h5EED_0042);
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_exec[i] = 0; m_op[i] = '0; m_qa[i] = '0; m_qb[i] = '0;
            m_va[i] = '0; m_vb[i] = '0; m_seq[i] = 0;
        end
        for (int k = 0; k < LAT; k++) begin p_v[k] = 0; p_tag[k] = '0; p_data[k] = '0; end
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(issue_ready == 1'b1, "R1 issue_ready", 64'(issue_ready), 64'd1);
        chk(disp_valid == 1'b0, "R1 disp_valid", 64'(disp_valid), 64'd0);
        chk(issue_tag == tag_t'(BASE), "R2 first tag", 64'(issue_tag), 64'(BASE));

        // R4 R2: fill every station with operand A pending on external tag 9
        for (int i = 0; i < N; i++) begin
            clr_stim();
            s_iv = 1; s_op = 3'(i); s_qa = 4'd9; s_va = 64'hDEAD;
            s_qb = '0; s_vb = 64'(100 + i);
            tick();
        end
        chk(issue_ready == 1'b0, "R3 full bank", 64'(issue_ready), 64'd0);
        chk(disp_valid == 1'b0, "R4 pending operand blocks", 64'(disp_valid), 64'd0);

        // R3: ready operands offered to a full bank are dropped
        clr_stim();
        s_iv = 1; s_op = 3'd2; s_va = 64'd7; s_vb = 64'd8;
        tick();
        clr_stim();
        tick();
        chk(disp_valid == 1'b0, "R3 refused issue ignored", 64'(disp_valid), 64'd0);

        // R5 R8: one broadcast wakes all three; dispatch in issue order
        clr_stim();
        s_xv = 1; s_xt = 4'd9; s_xd = 64'h1234_5678;
        tick();
        chk(disp_valid && disp_tag == tag_t'(BASE) && disp_src_a == 64'h1234_5678,
            "R5 wakeup capture", disp_src_a, 64'h1234_5678);
        idle(12);
        chk(issue_ready == 1'b1 && issue_tag == tag_t'(BASE), "R9 stations released",
            64'(issue_tag), 64'(BASE));

        // R6: issue while the producer tag is on the bus
        clr_stim();
        s_iv = 1; s_op = 3'd0; s_qa = 4'd10; s_va = 64'hBAD;
        s_qb = '0; s_vb = 64'd5;
        s_xv = 1; s_xt = 4'd10; s_xd = 64'hCAFE_F00D;
        tick();
        chk(disp_valid == 1'b1 && disp_src_a == 64'hCAFE_F00D, "R6 issue-time capture",
            disp_src_a, 64'hCAFE_F00D);
        idle(8);

        // R8: make station 0 the youngest, then release all at once
        clr_stim(); s_iv = 1; s_qa = 4'd11; tick();   // station 0
        clr_stim(); s_iv = 1; s_qa = 4'd12; tick();   // station 1
        clr_stim(); s_iv = 1; s_qa = 4'd11; tick();   // station 2
        clr_stim(); s_xv = 1; s_xt = 4'd11; s_xd = 64'd3; tick(); // stations 0,2 run
        idle(6);
        clr_stim(); s_iv = 1; s_qa = 4'd12; tick();   // station 0 again, youngest
        clr_stim(); s_xv = 1; s_xt = 4'd12; s_xd = 64'd9; tick();
        chk(disp_valid && disp_tag == tag_t'(BASE + 1), "R8 oldest before lower index",
            64'(disp_tag), 64'(BASE + 1));
        idle(8);

        // random mix, operands tied to own and external producers
        for (int c = 0; c < 4000; c++) begin
            int pick;
            clr_stim();
            if ($urandom_range(99) < 60) begin
                s_iv = 1;
                s_op = 3'($urandom_range(2));
                s_va = {$urandom, $urandom};
                s_vb = {$urandom, $urandom};
                for (int s = 0; s < 2; s++) begin
                    int r;
                    tag_t t;
                    r = $urandom_range(3);
                    t = '0;
                    if (r == 1) t = tag_t'($urandom_range(7, 4));
                    else if (r == 2) begin
                        pick = $urandom_range(N - 1);
                        if (m_busy[pick]) t = tag_t'(BASE + pick);
                    end
                    if (s == 0) s_qa = t; else s_qb = t;
                end
            end
            if ($urandom_range(99) < 35) begin
                s_xv = 1; s_xt = tag_t'($urandom_range(7, 4)); s_xd = {$urandom, $urandom};
            end
            tick();
        end
        idle(20);
        chk(issue_ready == 1'b1 && disp_valid == 1'b0, "R9 drained", 64'(issue_ready), 64'd1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule